// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block connects a processor-side word request port to an asynchronous external memory bus. The bus has a 16-bit data path and a 19-bit word address. The block serves two spaces: a code space, which is read only, and a data space, which is read and written. Each external access runs through a fixed sequence of phases. An address-latch phase comes first. Then come a setup window, a strobe window and a hold window. The length of each window is taken from a timing configuration register.

The data space has its own active-low select, which stays asserted from setup through hold. It also has a read strobe and two byte write strobes. In the code space, the program select itself acts as the read strobe. Code fetches can continue as a burst. The lowest three address lines are driven directly, so a sequential code word can be fetched without a new latch phase by changing only those three bits. A burst can therefore cover up to eight words. It ends on any jump, on a data-space request, or when the low three bits would wrap around.

A master sets the timing once through the configuration port and then issues requests with a valid/ready handshake. It receives a one-cycle response pulse for every completed access.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, all selects and strobes (`dm_cs_n`, `pm_cs_n`, `rd_n`, `wrh_n`, `wrl_n`) are high. In addition, `ale` is low, `resp_valid` is low and `req_ready` is high.
- R2: Every access that starts from idle begins with exactly one cycle in which `ale` is high. That cycle is the first cycle after the request is accepted, and no select or strobe is active during it.
- R3: The configuration word holds three fields: setup count in bits [2:0], strobe count in bits [5:3] and hold count in bits [8:6]. After the latch cycle come `setup` idle-strobe cycles, then `strobe+1` strobe cycles, then `hold` cycles. For a data access, `dm_cs_n` is low through all setup, strobe and hold cycles.
- R4: Read data is sampled from `ext_din` in the last strobe cycle. It is returned on `resp_rdata` with `resp_valid` high in the following cycle. Every access, including a write, produces one `resp_valid` cycle.
- R5: During strobe, a data write drives `wrh_n` low when `req_be[1]` is set and `wrl_n` low when `req_be[0]` is set, so a full-word write (`req_be`=2'b11) asserts both. `ext_dout` carries the write data, and `ext_doe` is high from setup through hold.
- R6: `dm_cs_n` is asserted only for data-space requests (`req_code`=0). `pm_cs_n` is asserted only for code-space requests (`req_code`=1), and only during strobe cycles. A code request is always a read, whatever the value of `req_write`.
- R7: In the last strobe cycle of a code read, a code request whose address is the previous address plus one is accepted without a latch cycle. `pm_cs_n` stays low without a gap, and only the low three address bits change.
- R8: A burst never continues across a wrap of the low three address bits from 7 to 0. The next word needs a new latch cycle, so at most 8 words share one latch cycle.
- R9: A non-sequential code request or a data request ends a burst. The current access completes its hold, `pm_cs_n` goes high, and the new access starts with a new latch cycle.
- R10: The timing fields are captured when each access is accepted. A configuration write during an access does not change that access; it takes effect for the next one.
- R11: `req_ready` is high only in idle, or in the last strobe cycle of a code read when the pending request qualifies for burst continuation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write enable for the timing register |
| cfg_wdata | input | 9 | Timing value {hold, strobe, setup} |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_code | input | 1 | 1 = code space, 0 = data space |
| req_write | input | 1 | 1 = write (data space only) |
| req_be | input | 2 | Byte enables {high, low} for writes |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read data |
| ext_addr | output | 19 | External word address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_din | input | 16 | External read data |
| dm_cs_n | output | 1 | Data memory select, active low |
| pm_cs_n | output | 1 | Program memory select / code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| ale | output | 1 | Address-latch phase indicator |

## Verification
Counted from the sample just before the accepting edge, the latch phase shows up one cycle later. The first strobe cycle comes 2+setup cycles later, and the response pulse 3+setup+strobe cycles later. The next access from idle is accepted 3+setup+strobe+hold cycles later. The bench drives inputs just after the rising edge and samples every output at the falling edge. A free-running cycle count stamps those samples, so each event is compared against these offsets, which are computed from the configured fields. In a burst, the bench counts latch cycles and the high gaps in the program select. The data of every response is compared against an address-derived memory model.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } xb_state_e;

  // True when nxt is the word right after prev and prev's low field
  // is not at its top value (so no wrap into the latched upper bits).
  function automatic logic burst_follows(input logic [31:0] prev,
                                         input logic [31:0] nxt,
                                         input int          low_w);
    logic [31:0] mask;
    mask = (32'd1 << low_w) - 32'd1;
    return (nxt == prev + 32'd1) && ((prev & mask) != mask);
  endfunction

endpackage

// File: rtl/xbus_addr_latch.sv
module xbus_addr_latch #(
  parameter int AW    = 19,
  parameter int LOW_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_full,
  input  logic          ld_low,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (ld_full)
      addr_q <= addr_in;
    else if (ld_low)
      addr_q[LOW_W-1:0] <= addr_in[LOW_W-1:0];
  end
endmodule

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
(
  input  xb_state_e  st,
  input  logic       code,
  input  logic       write,
  input  logic [1:0] be,
  output logic       ale,
  output logic       dm_cs_n,
  output logic       pm_cs_n,
  output logic       rd_n,
  output logic       wrh_n,
  output logic       wrl_n,
  output logic       doe
);
  logic in_strobe, in_window;

  assign in_strobe = (st == ST_STROBE);
  assign in_window = (st == ST_SETUP) || in_strobe || (st == ST_HOLD);

  assign ale     = (st == ST_LATCH);
  assign dm_cs_n = !(!code && in_window);
  assign pm_cs_n = !(code && in_strobe);
  assign rd_n    = !(!code && !write && in_strobe);
  assign wrh_n   = !(write && be[1] && in_strobe);
  assign wrl_n   = !(write && be[0] && in_strobe);
  assign doe     = write && in_window;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 16,
  parameter int CW         = 3,
  parameter int LOW_W      = 3,
  parameter int RST_SETUP  = 1,
  parameter int RST_STROBE = 1,
  parameter int RST_HOLD   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [3*CW-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_code,
  input  logic            req_write,
  input  logic [1:0]      req_be,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            resp_valid,
  output logic [DW-1:0]   resp_rdata,
  output logic [AW-1:0]   ext_addr,
  output logic [DW-1:0]   ext_dout,
  output logic            ext_doe,
  input  logic [DW-1:0]   ext_din,
  output logic            dm_cs_n,
  output logic            pm_cs_n,
  output logic            rd_n,
  output logic            wrh_n,
  output logic            wrl_n,
  output logic            ale
);
  localparam int CFG_W = 3 * CW;
  localparam logic [CFG_W-1:0] CFG_RST =
    {CW'(RST_HOLD), CW'(RST_STROBE), CW'(RST_SETUP)};

  xb_state_e        state, nxt_state;
  logic [CFG_W-1:0] cfg_q, tm_q;
  logic             cur_code, cur_write;
  logic [1:0]       cur_be;
  logic [DW-1:0]    cur_wdata;
  logic [AW-1:0]    addr_q;
  logic             t_load, t_zero;
  logic [CW-1:0]    t_val;

  // Named internal events
  logic idle, strobe_last, seq_ok, burst_take_ok, accept, new_cycle, burst_go;
  logic [CW-1:0] tm_setup, tm_strb, tm_hold, cfg_strb;

  assign tm_setup = tm_q[CW-1:0];
  assign tm_strb  = tm_q[2*CW-1:CW];
  assign tm_hold  = tm_q[3*CW-1:2*CW];
  assign cfg_strb = cfg_q[2*CW-1:CW];

  assign idle          = (state == ST_IDLE);
  assign strobe_last   = (state == ST_STROBE) && t_zero;
  assign seq_ok        = burst_follows(32'(addr_q), 32'(req_addr), LOW_W);
  assign burst_take_ok = strobe_last && cur_code && req_code && seq_ok;
  assign req_ready     = idle || burst_take_ok;
  assign accept        = req_valid && req_ready;
  assign new_cycle     = accept && idle;
  assign burst_go      = accept && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q      <= CFG_RST;
      cur_code  <= 1'b0;
      cur_write <= 1'b0;
      cur_be    <= 2'b00;
      cur_wdata <= '0;
    end else if (accept) begin
      tm_q      <= cfg_q;
      cur_code  <= req_code;
      cur_write <= req_write && !req_code;
      cur_be    <= req_be;
      cur_wdata <= req_wdata;
    end
  end

  xbus_addr_latch #(.AW(AW), .LOW_W(LOW_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ld_full(new_cycle), .ld_low(burst_go),
    .addr_in(req_addr), .addr_q(addr_q)
  );

  xbus_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  always_comb begin
    nxt_state = state;
    t_load    = 1'b0;
    t_val     = '0;
    unique case (state)
      ST_IDLE: if (new_cycle) nxt_state = ST_LATCH;
      ST_LATCH: begin
        t_load = 1'b1;
        if (tm_setup != '0) begin
          nxt_state = ST_SETUP;
          t_val     = tm_setup - 1'b1;
        end else begin
          nxt_state = ST_STROBE;
          t_val     = tm_strb;
        end
      end
      ST_SETUP: if (t_zero) begin
        nxt_state = ST_STROBE;
        t_load    = 1'b1;
        t_val     = tm_strb;
      end
      ST_STROBE: if (t_zero) begin
        if (burst_go) begin
          t_load = 1'b1;
          t_val  = cfg_strb;
        end else if (tm_hold != '0) begin
          nxt_state = ST_HOLD;
          t_load    = 1'b1;
          t_val     = tm_hold - 1'b1;
        end else begin
          nxt_state = ST_IDLE;
        end
      end
      ST_HOLD: if (t_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= strobe_last;
      if (strobe_last && !cur_write) resp_rdata <= ext_din;
    end
  end

  xbus_strobe_gen u_strb (
    .st(state), .code(cur_code), .write(cur_write), .be(cur_be),
    .ale(ale), .dm_cs_n(dm_cs_n), .pm_cs_n(pm_cs_n), .rd_n(rd_n),
    .wrh_n(wrh_n), .wrl_n(wrl_n), .doe(ext_doe)
  );

  assign ext_addr = addr_q;
  assign ext_dout = cur_wdata;

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && pm_cs_n && wrh_n && wrl_n && dm_cs_n));
  // R6
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_cs_n |-> dm_cs_n);
  // R3
  rd_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dm_cs_n);
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrh_n || !wrl_n) |-> (ext_doe && !dm_cs_n));
  // R7
  burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_cs_n && $past(!pm_cs_n)) |->
      (ext_addr[AW-1:LOW_W] == $past(ext_addr[AW-1:LOW_W])));
  // R8
  burst_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_cs_n && $past(!pm_cs_n) && ext_addr != $past(ext_addr)) |->
      ($past(ext_addr[LOW_W-1:0]) != '1));
  // R11
  ready_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !idle) |-> (!pm_cs_n && t_zero));
  // R4
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(strobe_last));
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0, req_code = 1'b0, req_write = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, resp_valid, ext_doe;
  logic [15:0] resp_rdata, ext_dout, ext_din;
  logic [18:0] ext_addr;
  logic        dm_cs_n, pm_cs_n, rd_n, wrh_n, wrl_n, ale;

  int n_tests = 0, n_fail = 0, cyc = 0, acc_cyc = 0;
  int ale_cnt, rd_cnt, dm_cnt, pm_cnt, pm_gaps, wrh_cnt, wrl_cnt, wr_ok;
  int first_rd, first_resp, resp_n;
  bit pm_seen, pm_prev_high;
  logic [15:0] resp_log [0:15];
  logic [15:0] exp_wdata = '0;

  xbus_ctrl i_xbus_ctrl (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [18:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  assign ext_din = mem_f(ext_addr);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (ale) ale_cnt++;
    if (!rd_n) begin rd_cnt++; if (first_rd < 0) first_rd = cyc; end
    if (!dm_cs_n) dm_cnt++;
    if (!pm_cs_n) begin
      pm_cnt++;
      if (pm_seen && pm_prev_high) pm_gaps++;
      pm_seen = 1'b1;
    end
    pm_prev_high = pm_cs_n;
    if (!wrh_n) wrh_cnt++;
    if (!wrl_n) wrl_cnt++;
    if ((!wrh_n || !wrl_n) && ext_doe && ext_dout == exp_wdata) wr_ok++;
    if (resp_valid) begin
      if (resp_n < 16) resp_log[resp_n] = resp_rdata;
      if (first_resp < 0) first_resp = cyc;
      resp_n++;
    end
  end

  task automatic clear_mon();
    ale_cnt = 0; rd_cnt = 0; dm_cnt = 0; pm_cnt = 0; pm_gaps = 0;
    wrh_cnt = 0; wrl_cnt = 0; wr_ok = 0; first_rd = -1; first_resp = -1;
    resp_n = 0; pm_seen = 1'b0; pm_prev_high = 1'b1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Caller is just past a rising edge.
  task automatic issue(input bit code, input bit wr, input logic [1:0] be,
                       input logic [18:0] addr, input logic [15:0] wd,
                       input bit drop);
    bit got = 1'b0;
    req_valid = 1'b1; req_code = code; req_write = wr; req_be = be;
    req_addr = addr; req_wdata = wd;
    while (!got) begin
      @(negedge clk);
      if (req_ready) begin acc_cyc = cyc; got = 1'b1; end
    end
    @(posedge clk); #1;
    if (drop) req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_cfg(input int s, input int w, input int h);
    cfg_we = 1'b1; cfg_wdata = {3'(h), 3'(w), 3'(s)};
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 selects", {dm_cs_n, pm_cs_n, rd_n, wrh_n, wrl_n}, 5'b11111);
    check("R1 ale", ale, 0);
    check("R1 ready", req_ready, 1);
    check("R1 resp_valid", resp_valid, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_read(input int s, input int w, input int h,
                        input logic [18:0] a);
    set_cfg(s, w, h);
    clear_mon();
    issue(1'b0, 1'b0, 2'b11, a, 16'h0, 1'b1);
    settle(30);
    check("R2 one latch", ale_cnt, 1);
    check("R3 rd start", first_rd - acc_cyc, 2 + s);
    check("R3 rd length", rd_cnt, w + 1);
    check("R3 dm length", dm_cnt, s + w + 1 + h);
    check("R4 resp time", first_resp - acc_cyc, 3 + s + w);
    check("R4 resp count", resp_n, 1);
    check("R4 rdata", resp_log[0], mem_f(a));
    check("R6 no pm on data", pm_cnt, 0);
  endtask

  task automatic t_write(input logic [1:0] be, input logic [15:0] wd);
    set_cfg(1, 2, 1);
    clear_mon();
    exp_wdata = wd;
    issue(1'b0, 1'b1, be, 19'h00321, wd, 1'b1);
    settle(30);
    check("R5 wrh", wrh_cnt, be[1] ? 3 : 0);
    check("R5 wrl", wrl_cnt, be[0] ? 3 : 0);
    check("R5 data driven", wr_ok, (be != 2'b00) ? 3 : 0);
    check("R5 no rd", rd_cnt, 0);
    check("R4 write resp", resp_n, 1);
  endtask

  task automatic t_code_single();
    set_cfg(2, 1, 1);
    clear_mon();
    issue(1'b1, 1'b1, 2'b11, 19'h01234, 16'hFFFF, 1'b1);
    settle(30);
    check("R6 pm length", pm_cnt, 2);
    check("R6 no dm", dm_cnt, 0);
    check("R6 code not write", wrh_cnt + wrl_cnt + rd_cnt, 0);
    check("R6 code rdata", resp_log[0], mem_f(19'h01234));
  endtask

  task automatic t_stream(input string tag, input logic [18:0] start,
                          input int n, input int jump_at,
                          input int exp_ale, input int exp_gaps);
    logic [18:0] addrs [0:15];
    set_cfg(1, 1, 1);
    clear_mon();
    for (int i = 0; i < n; i++)
      addrs[i] = start + 19'(i) + ((jump_at >= 0 && i >= jump_at) ? 19'h40 : 19'h0);
    for (int i = 0; i < n; i++)
      issue(1'b1, 1'b0, 2'b11, addrs[i], 16'h0, i == n - 1);
    settle(30);
    check({tag, " latch count"}, ale_cnt, exp_ale);
    check({tag, " pm gaps"}, pm_gaps, exp_gaps);
    check({tag, " resp count"}, resp_n, n);
    for (int i = 0; i < n; i++)
      check({tag, " burst data"}, resp_log[i], mem_f(addrs[i]));
    if (exp_ale == 1) check({tag, " pm length"}, pm_cnt, 2 * n);
  endtask

  task automatic t_code_then_data();
    set_cfg(1, 2, 1);
    clear_mon();
    issue(1'b1, 1'b0, 2'b11, 19'h00300, 16'h0, 1'b0);
    issue(1'b0, 1'b0, 2'b11, 19'h00301, 16'h0, 1'b1);
    settle(30);
    check("R9 data ends burst latch", ale_cnt, 2);
    check("R9 pm length", pm_cnt, 3);
    check("R9 dm length", dm_cnt, 5);
    check("R9 data rdata", resp_log[1], mem_f(19'h00301));
  endtask

  task automatic t_cfg_mid();
    set_cfg(1, 2, 1);
    clear_mon();
    issue(1'b0, 1'b0, 2'b11, 19'h00040, 16'h0, 1'b1);
    set_cfg(0, 4, 0);
    settle(30);
    check("R10 old timing kept", rd_cnt, 3);
    clear_mon();
    issue(1'b0, 1'b0, 2'b11, 19'h00041, 16'h0, 1'b1);
    settle(30);
    check("R10 new strobe", rd_cnt, 5);
    check("R10 new setup", first_rd - acc_cyc, 2);
    check("R10 new hold", dm_cnt, 5);
  endtask

  task automatic t_ready();
    int a1;
    set_cfg(1, 2, 1);
    clear_mon();
    issue(1'b0, 1'b0, 2'b11, 19'h00500, 16'h0, 1'b0);
    a1 = acc_cyc;
    issue(1'b0, 1'b0, 2'b11, 19'h00501, 16'h0, 1'b1);
    settle(30);
    check("R11 second accept", acc_cyc - a1, 7);
    check("R11 two latches", ale_cnt, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read(1, 2, 1, 19'h12345);
    t_read(0, 0, 0, 19'h00007);
    t_read(3, 4, 2, 19'h7FFFF);
    t_write(2'b11, 16'hBEEF);
    t_write(2'b10, 16'h1234);
    t_write(2'b01, 16'h8001);
    t_code_single();
    t_stream("R7 full burst", 19'h00100, 8, -1, 1, 0);
    t_stream("R8 wrap", 19'h00205, 4, -1, 2, 1);
    t_stream("R8 nine words", 19'h00108, 9, -1, 2, 1);
    t_stream("R9 jump", 19'h00100, 4, 2, 2, 1);
    t_code_then_data();
    t_cfg_mid();
    t_ready();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule